// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a small processor with a 9-bit word. A tick counter steps through every instruction one clock at a time. On each tick a combinational decoder turns the tick number, the held instruction word and the zero flag of the result register into a set of control strobes. These strobes steer the shared bus and the load enables of the datapath. All strobes are low unless the current tick needs them.

Every instruction begins with the same three-tick fetch. In the first tick the address register loads from the program counter. The second tick is a wait that covers the one-cycle read latency of the synchronous memory, and the program counter increments during it. In the third tick the instruction register loads. An execute phase of one to three ticks follows. The tick that raises Done is always the last tick of the instruction, and the counter then returns to the first fetch tick. The program counter is register code 7 and can be used as an operand like any other register.

The instruction word is split into three fields. Bits [8:6] hold the opcode, bits [5:3] hold the destination code x, and bits [2:0] hold the source code y. Register selects are 8-bit one-hot vectors in which bit n stands for register code n.

Top module: `ctrl_seq`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, every output is zero. The first fetch tick follows after that.
- R2: Fetch tick T0 drives reg_out_o = 8'b1000_0000 (register 7, the program counter) and addr_load_o. No other strobe is active.
- R3: Fetch tick T1 drives only pc_incr_o.
- R4: Fetch tick T2 drives only ir_load_o.
- R5: Opcode 3'b000 (move) is four ticks long. In T3 it drives reg_out_o = one-hot(y), reg_in_o = one-hot(x) and done_o.
- R6: Opcodes 3'b010 (add), 3'b011 (subtract) and 3'b111 (AND) are six ticks long. T3 drives one-hot(x) on reg_out_o together with a_load_o. T4 drives one-hot(y) on reg_out_o, g_load_o, and alu_op_o equal to 2'b00, 2'b01 or 2'b10 respectively. T5 drives g_out_o, reg_in_o = one-hot(x) and done_o.
- R7: Opcode 3'b001 (move immediate) is six ticks long. T3 drives one-hot(7) on reg_out_o, addr_load_o and pc_incr_o. T4 drives nothing. T5 drives din_sel_o, reg_in_o = one-hot(x) and done_o. The y field has no effect on any output.
- R8: Opcode 3'b100 (load) is six ticks long. T3 drives one-hot(y) on reg_out_o and addr_load_o. T4 drives nothing. T5 drives din_sel_o, reg_in_o = one-hot(x) and done_o.
- R9: Opcode 3'b101 (store) is five ticks long. T3 drives one-hot(y) on reg_out_o and addr_load_o. T4 drives one-hot(x) on reg_out_o, dout_load_o, write_o and done_o.
- R10: Opcode 3'b110 (move if not zero) is four ticks long and drives done_o in T3. In that tick it also drives reg_out_o = one-hot(y) and reg_in_o = one-hot(x), but only when g_zero_i is low.
- R11: In any tick, at most one bus source is active, counting the eight bits of reg_out_o, din_sel_o and g_out_o together.
- R12: The tick after a tick with done_o high is always fetch tick T0.
- R13: alu_op_o is 2'b00 in every tick where g_load_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 9 | Instruction register contents: opcode [8:6], x [5:3], y [2:0] |
| g_zero_i | input | 1 | High when the result register holds zero |
| reg_out_o | output | 8 | One-hot select of the register that drives the bus |
| reg_in_o | output | 8 | One-hot load enable of a general register |
| addr_load_o | output | 1 | Load the address register from the bus |
| a_load_o | output | 1 | Load the ALU operand register from the bus |
| g_load_o | output | 1 | Load the result register from the ALU |
| g_out_o | output | 1 | Result register drives the bus |
| din_sel_o | output | 1 | Memory/IO read data drives the bus |
| dout_load_o | output | 1 | Load the write-data register from the bus |
| write_o | output | 1 | Write strobe to the addressed device |
| pc_incr_o | output | 1 | Increment the program counter |
| ir_load_o | output | 1 | Load the instruction register from memory data |
| alu_op_o | output | 2 | ALU function: 00 add, 01 subtract, 10 AND |
| done_o | output | 1 | The current instruction ends on the next edge |

## Verification
Each of the eight opcodes runs back to back, so a wrong instruction length shows up as a misaligned fetch in the next instruction. Distinct x and y codes catch swapped operand fields. Codes equal to 7 show that the program counter acts as an ordinary operand. The two ALU opcodes that differ only in the function code tell the alu_op encodings apart. Move immediate runs twice with different y fields to show that y is ignored. The conditional move runs with the zero flag both high and low.

// File: rtl/ctrl_seq_pkg.sv
package ctrl_seq_pkg;
  localparam int WORD_W  = 9;
  localparam int CODE_W  = 3;
  localparam int NREG    = 1 << CODE_W;
  localparam int PC_CODE = NREG - 1;
  localparam int TICK_W  = 3;
  localparam int ALU_W   = 2;

  typedef enum logic [2:0] {
    OP_MOV  = 3'b000,
    OP_MVI  = 3'b001,
    OP_ADD  = 3'b010,
    OP_SUB  = 3'b011,
    OP_LD   = 3'b100,
    OP_ST   = 3'b101,
    OP_MVNZ = 3'b110,
    OP_AND  = 3'b111
  } op_e;

  localparam logic [TICK_W-1:0] T0 = 3'd0;
  localparam logic [TICK_W-1:0] T1 = 3'd1;
  localparam logic [TICK_W-1:0] T2 = 3'd2;
  localparam logic [TICK_W-1:0] T3 = 3'd3;
  localparam logic [TICK_W-1:0] T4 = 3'd4;
  localparam logic [TICK_W-1:0] T5 = 3'd5;

  typedef struct packed {
    logic [NREG-1:0]  reg_out;
    logic [NREG-1:0]  reg_in;
    logic             addr_load;
    logic             a_load;
    logic             g_load;
    logic             g_out;
    logic             din_sel;
    logic             dout_load;
    logic             write;
    logic             pc_incr;
    logic             ir_load;
    logic [ALU_W-1:0] alu_op;
    logic             done;
  } ctrl_t;
endpackage

// File: rtl/ctrl_seq_tick.sv
module ctrl_seq_tick
  import ctrl_seq_pkg::*;
#(
  parameter int TW = TICK_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  output logic          run_o,
  output logic [TW-1:0] tick_o
);
  localparam logic [TW-1:0] LAST = TW'(T5);

  logic          run_q;
  logic [TW-1:0] tick_q;

  // one quiet cycle after reset before the first fetch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      tick_q <= '0;
    end else begin
      run_q <= 1'b1;
      if (run_q) begin
        if (done_i || tick_q == LAST) tick_q <= '0;
        else                          tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign run_o  = run_q;
  assign tick_o = tick_q;

  AST_DONE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && done_i) |=> (tick_q == '0)) else $error("restart"); // R12
  AST_TICK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q <= LAST) else $error("tick range"); // R12
endmodule

// File: rtl/ctrl_seq_dec.sv
module ctrl_seq_dec
  import ctrl_seq_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NR = NREG,
  parameter int TW = TICK_W
) (
  input  logic [TW-1:0]     tick_i,
  input  logic [WORD_W-1:0] ir_i,
  input  logic              g_zero_i,
  output ctrl_t             ctrl_o
);
  op_e             op;
  logic [CW-1:0]   x_code, y_code;
  logic [NR-1:0]   x_sel, y_sel, pc_sel;

  assign op     = op_e'(ir_i[WORD_W-1 -: 3]);
  assign x_code = ir_i[2*CW-1 -: CW];
  assign y_code = ir_i[CW-1:0];

  for (genvar g = 0; g < NR; g++) begin : g_sel
    assign x_sel[g]  = (x_code == CW'(g));
    assign y_sel[g]  = (y_code == CW'(g));
    assign pc_sel[g] = (g == PC_CODE);
  end

  function automatic logic [ALU_W-1:0] alu_code(op_e o);
    case (o)
      OP_SUB:  return 2'b01;
      OP_AND:  return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  logic is_alu;
  assign is_alu = (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND);

  always_comb begin
    ctrl_o = '0;
    case (tick_i)
      T0: begin
        ctrl_o.reg_out   = pc_sel;
        ctrl_o.addr_load = 1'b1;
      end
      T1: ctrl_o.pc_incr = 1'b1;
      T2: ctrl_o.ir_load = 1'b1;
      T3: begin
        case (op)
          OP_MOV: begin
            ctrl_o.reg_out = y_sel;
            ctrl_o.reg_in  = x_sel;
            ctrl_o.done    = 1'b1;
          end
          OP_MVI: begin
            ctrl_o.reg_out   = pc_sel;
            ctrl_o.addr_load = 1'b1;
            ctrl_o.pc_incr   = 1'b1;
          end
          OP_LD, OP_ST: begin
            ctrl_o.reg_out   = y_sel;
            ctrl_o.addr_load = 1'b1;
          end
          OP_MVNZ: begin
            ctrl_o.done = 1'b1;
            if (!g_zero_i) begin
              ctrl_o.reg_out = y_sel;
              ctrl_o.reg_in  = x_sel;
            end
          end
          default: begin
            ctrl_o.reg_out = x_sel;
            ctrl_o.a_load  = 1'b1;
          end
        endcase
      end
      T4: begin
        if (is_alu) begin
          ctrl_o.reg_out = y_sel;
          ctrl_o.g_load  = 1'b1;
          ctrl_o.alu_op  = alu_code(op);
        end else if (op == OP_ST) begin
          ctrl_o.reg_out   = x_sel;
          ctrl_o.dout_load = 1'b1;
          ctrl_o.write     = 1'b1;
          ctrl_o.done      = 1'b1;
        end
        // load and immediate: memory wait tick
      end
      T5: begin
        ctrl_o.reg_in = x_sel;
        ctrl_o.done   = 1'b1;
        if (is_alu) ctrl_o.g_out   = 1'b1;
        else        ctrl_o.din_sel = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/ctrl_seq.sv
module ctrl_seq
  import ctrl_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] ir_i,
  input  logic              g_zero_i,
  output logic [NREG-1:0]   reg_out_o,
  output logic [NREG-1:0]   reg_in_o,
  output logic              addr_load_o,
  output logic              a_load_o,
  output logic              g_load_o,
  output logic              g_out_o,
  output logic              din_sel_o,
  output logic              dout_load_o,
  output logic              write_o,
  output logic              pc_incr_o,
  output logic              ir_load_o,
  output logic [ALU_W-1:0]  alu_op_o,
  output logic              done_o
);
  logic              run;
  logic [TICK_W-1:0] tick;
  ctrl_t             dec, ctrl;

  ctrl_seq_tick #(.TW(TICK_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (ctrl.done),
    .run_o  (run),
    .tick_o (tick)
  );

  ctrl_seq_dec #(.CW(CODE_W), .NR(NREG), .TW(TICK_W)) u_dec (
    .tick_i   (tick),
    .ir_i     (ir_i),
    .g_zero_i (g_zero_i),
    .ctrl_o   (dec)
  );

  assign ctrl = run ? dec : '0;

  assign reg_out_o   = ctrl.reg_out;
  assign reg_in_o    = ctrl.reg_in;
  assign addr_load_o = ctrl.addr_load;
  assign a_load_o    = ctrl.a_load;
  assign g_load_o    = ctrl.g_load;
  assign g_out_o     = ctrl.g_out;
  assign din_sel_o   = ctrl.din_sel;
  assign dout_load_o = ctrl.dout_load;
  assign write_o     = ctrl.write;
  assign pc_incr_o   = ctrl.pc_incr;
  assign ir_load_o   = ctrl.ir_load;
  assign alu_op_o    = ctrl.alu_op;
  assign done_o      = ctrl.done;

  AST_ONE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({reg_out_o, din_sel_o, g_out_o}) <= 1) else $error("bus"); // R11
  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (ctrl == '0)) else $error("quiet"); // R1
  AST_FETCH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick == T0) |-> (addr_load_o && reg_out_o[PC_CODE])) else $error("fetch"); // R2
  AST_IR_AFTER_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_load_o |-> $past(pc_incr_o)) else $error("ir load"); // R4
  AST_WRITE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_o |-> (done_o && dout_load_o)) else $error("write"); // R9
  AST_ALU_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !g_load_o |-> (alu_op_o == 2'b00)) else $error("alu op"); // R13
endmodule

// File: tb/sim_ctrl_seq.sv
module sim_ctrl_seq;
  import ctrl_seq_pkg::*;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [WORD_W-1:0] ir_i = '0;
  logic              g_zero_i = 1'b0;
  logic [7:0]        reg_out_o, reg_in_o;
  logic              addr_load_o, a_load_o, g_load_o, g_out_o, din_sel_o;
  logic              dout_load_o, write_o, pc_incr_o, ir_load_o, done_o;
  logic [1:0]        alu_op_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ctrl_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ir_i(ir_i), .g_zero_i(g_zero_i),
    .reg_out_o(reg_out_o), .reg_in_o(reg_in_o), .addr_load_o(addr_load_o),
    .a_load_o(a_load_o), .g_load_o(g_load_o), .g_out_o(g_out_o),
    .din_sel_o(din_sel_o), .dout_load_o(dout_load_o), .write_o(write_o),
    .pc_incr_o(pc_incr_o), .ir_load_o(ir_load_o), .alu_op_o(alu_op_o),
    .done_o(done_o)
  );

  // flag order: addr, a, gload, gout, din, dout, write, pc, ir
  localparam logic [8:0] F_ADDR = 9'b1_0000_0000;
  localparam logic [8:0] F_A    = 9'b0_1000_0000;
  localparam logic [8:0] F_GL   = 9'b0_0100_0000;
  localparam logic [8:0] F_GO   = 9'b0_0010_0000;
  localparam logic [8:0] F_DIN  = 9'b0_0001_0000;
  localparam logic [8:0] F_DOUT = 9'b0_0000_1000;
  localparam logic [8:0] F_WR   = 9'b0_0000_0100;
  localparam logic [8:0] F_PC   = 9'b0_0000_0010;
  localparam logic [8:0] F_IR   = 9'b0_0000_0001;

  logic [27:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [7:0] oh(input logic [2:0] c);
    return 8'(1) << c;
  endfunction

  function automatic logic [27:0] vec(input logic [7:0] ro, input logic [7:0] ri,
                                      input logic [8:0] f, input logic [1:0] alu,
                                      input logic dn);
    return {ro, ri, f, alu, dn};
  endfunction

  function automatic logic [27:0] act();
    return {reg_out_o, reg_in_o, addr_load_o, a_load_o, g_load_o, g_out_o,
            din_sel_o, dout_load_o, write_o, pc_incr_o, ir_load_o, alu_op_o, done_o};
  endfunction

  task automatic check(input string tag, input logic [27:0] a, input logic [27:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic push(input logic [27:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // driver: expected ticks from the requirements, then apply the instruction
  task automatic run_instr(input logic [2:0] op, input logic [2:0] x,
                           input logic [2:0] y, input logic gz, input string tag);
    int n;
    push(vec(oh(3'd7), 8'h0, F_ADDR, 2'b00, 1'b0), "R2 R12");
    push(vec(8'h0, 8'h0, F_PC, 2'b00, 1'b0), "R3");
    push(vec(8'h0, 8'h0, F_IR, 2'b00, 1'b0), "R4");
    case (op)
      3'b000: begin
        push(vec(oh(y), oh(x), 9'h0, 2'b00, 1'b1), tag); n = 4;
      end
      3'b001: begin
        push(vec(oh(3'd7), 8'h0, F_ADDR | F_PC, 2'b00, 1'b0), tag);
        push(vec(8'h0, 8'h0, 9'h0, 2'b00, 1'b0), tag);
        push(vec(8'h0, oh(x), F_DIN, 2'b00, 1'b1), tag); n = 6;
      end
      3'b010, 3'b011, 3'b111: begin
        logic [1:0] code;
        code = (op == 3'b010) ? 2'b00 : (op == 3'b011) ? 2'b01 : 2'b10;
        push(vec(oh(x), 8'h0, F_A, 2'b00, 1'b0), tag);
        push(vec(oh(y), 8'h0, F_GL, code, 1'b0), tag);
        push(vec(8'h0, oh(x), F_GO, 2'b00, 1'b1), tag); n = 6;
      end
      3'b100: begin
        push(vec(oh(y), 8'h0, F_ADDR, 2'b00, 1'b0), tag);
        push(vec(8'h0, 8'h0, 9'h0, 2'b00, 1'b0), tag);
        push(vec(8'h0, oh(x), F_DIN, 2'b00, 1'b1), tag); n = 6;
      end
      3'b101: begin
        push(vec(oh(y), 8'h0, F_ADDR, 2'b00, 1'b0), tag);
        push(vec(oh(x), 8'h0, F_DOUT | F_WR, 2'b00, 1'b1), tag); n = 5;
      end
      default: begin
        if (gz) push(vec(8'h0, 8'h0, 9'h0, 2'b00, 1'b1), tag);
        else    push(vec(oh(y), oh(x), 9'h0, 2'b00, 1'b1), tag);
        n = 4;
      end
    endcase
    ir_i     = {op, x, y};
    g_zero_i = gz;
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && exp_q.size() > 0) begin
      logic [27:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, act(), e);
      checks++;
      if ($countones({reg_out_o, din_sel_o, g_out_o}) > 1) begin
        errors++;
        $display("FAIL R11 actual=%0d sources expected<=1",
                 $countones({reg_out_o, din_sel_o, g_out_o}));
      end
      checks++;
      if (!g_load_o && alu_op_o !== 2'b00) begin
        errors++;
        $display("FAIL R13 actual=%b expected=00", alu_op_o);
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", act(), '0);
    rst_ni = 1'b1;
    #1;
    check("R1", act(), '0);
    @(posedge clk);
    #1;
    run_instr(3'b000, 3'd2, 3'd5, 1'b0, "R5");
    run_instr(3'b000, 3'd7, 3'd7, 1'b0, "R5");
    run_instr(3'b010, 3'd1, 3'd3, 1'b0, "R6");
    run_instr(3'b011, 3'd4, 3'd0, 1'b0, "R6");
    run_instr(3'b111, 3'd6, 3'd6, 1'b0, "R6");
    run_instr(3'b001, 3'd3, 3'd5, 1'b0, "R7");
    run_instr(3'b001, 3'd3, 3'd0, 1'b1, "R7");
    run_instr(3'b100, 3'd0, 3'd7, 1'b0, "R8");
    run_instr(3'b101, 3'd5, 3'd2, 1'b0, "R9");
    run_instr(3'b110, 3'd1, 3'd4, 1'b0, "R10");
    run_instr(3'b110, 3'd1, 3'd4, 1'b1, "R10");
    run_instr(3'b000, 3'd0, 3'd1, 1'b1, "R5 R12");
    @(negedge clk);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule